// File: doc/BRIEF.md
# Glitch-Free Clock Select and Gate

This block drives one output clock from either of two free-running input clocks. A select input picks the source, and an enable input gates the output. Every change to the output is timed so that the output never shows a shortened high pulse or a spike. The enable can be active-high or active-low, chosen by a parameter.

Each input clock has its own path with a grant flag. A path requests its grant when it is selected, the enable is active, and the other path's grant is clear. That request passes through `SYNC_STAGES` rising-edge flops clocked by the path's own clock. A final flop then updates the grant on the falling edge of that clock. The output is the OR of each clock ANDed with its grant.

With this structure, a switch happens in a fixed order. The old clock completes its high phase. The output then stays low until the new clock is low. After that, the output follows the new clock. To use the block as a plain clock gate, hold the select steady and toggle the enable.

Top module: `clk_switch`

## Requirements
- R1: While reset is asserted and right after it is released, path 0 holds the grant. With select 0 and enable active, the output follows input clock 0 from the first cycle.
- R2: When the enable is inactive, the output settles low and stays low. In the bench, settling takes at most 120 ns.
- R3: A grant flag changes only while its own clock is low. As a result, every output high pulse lasts exactly one full high phase of an input clock.
- R4: The parameter `EN_ACTIVE_HIGH` sets the enable polarity. A value of 1 (the default) means a high level enables the output. A value of 0 means a low level enables it.
- R5: If the select changes while the old clock is high, the output stays high until that clock's next falling edge.
- R6: After the old clock falls, the output stays low until the new clock has been low. No output low interval is shorter than the shorter low phase of the two inputs.
- R7: Once settled after a select change, the output follows the newly selected clock. A select value of 0 means input clock 0, and a value of 1 means input clock 1. This holds in both directions.
- R8: At most one path holds its grant at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk0 | input | 1 | Input clock 0, selected by select value 0 |
| clk1 | input | 1 | Input clock 1, selected by select value 1 |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Source select: 0 picks clk0, 1 picks clk1 |
| en | input | 1 | Output enable; polarity set by `EN_ACTIVE_HIGH` |
| clk_out | output | 1 | Gated and selected output clock |

## Verification
The bench builds two copies with `SYNC_STAGES` = 2. One copy uses the default `EN_ACTIVE_HIGH` = 1, and the other uses `EN_ACTIVE_HIGH` = 0 with an inverted enable. The two outputs must match at every sample, which covers the polarity option. The input clocks have unrelated periods, 5 ns and 7 ns, so select and enable changes land at every phase of both clocks. Pulse-width monitors then catch any runt high pulse or short low gap during a switch or a gate change.

// File: rtl/clk_switch.sv
module clk_switch #(
  parameter bit EN_ACTIVE_HIGH = 1'b1,
  parameter int SYNC_STAGES    = 2
) (
  input  logic clk0,
  input  logic clk1,
  input  logic rst_n,
  input  logic sel,
  input  logic en,
  output logic clk_out
);
  logic [1:0] ck;
  logic [1:0] want;
  logic [1:0] gnt;
  logic       en_on;

  assign ck      = {clk1, clk0};
  assign en_on   = EN_ACTIVE_HIGH ? en : ~en;
  assign want[0] = en_on & ~sel & ~gnt[1];
  assign want[1] = en_on &  sel & ~gnt[0];

  for (genvar i = 0; i < 2; i++) begin : g_path
    localparam bit RST = (i == 0);
    logic [SYNC_STAGES-1:0] chain;
    logic                   g;

    always_ff @(posedge ck[i] or negedge rst_n)
      if (!rst_n) chain <= {SYNC_STAGES{RST}};
      else        chain <= {chain[SYNC_STAGES-2:0], want[i]};

    always_ff @(negedge ck[i] or negedge rst_n)
      if (!rst_n) g <= RST;
      else        g <= chain[SYNC_STAGES-1];

    assign gnt[i] = g;
  end

  assign clk_out = |(gnt & ck);
endmodule

// File: rtl/clk_switch_chk.sv
module clk_switch_chk (
  input logic clk0,
  input logic clk1,
  input logic rst_n,
  input logic q0,
  input logic q1
);
  logic r0, r1;

  always_ff @(posedge clk0 or negedge rst_n)
    if (!rst_n) r0 <= 1'b1;
    else        r0 <= q0;

  always_ff @(posedge clk1 or negedge rst_n)
    if (!rst_n) r1 <= 1'b0;
    else        r1 <= q1;

  p_one_grant_c0_r8: assert property (@(posedge clk0) disable iff (!rst_n) $onehot0({q0, q1}));
  p_one_grant_c1_r8: assert property (@(posedge clk1) disable iff (!rst_n) $onehot0({q0, q1}));
  p_grant0_steady_r3: assert property (@(negedge clk0) disable iff (!rst_n) q0 == r0);
  p_grant1_steady_r3: assert property (@(negedge clk1) disable iff (!rst_n) q1 == r1);
endmodule

bind clk_switch clk_switch_chk chk_i (
  .clk0 (clk0),
  .clk1 (clk1),
  .rst_n(rst_n),
  .q0   (gnt[0]),
  .q1   (gnt[1])
);

// File: tb/clk_switch_tb_top.sv
`timescale 1ns/1ps
module clk_switch_tb_top;
  logic clk0 = 1'b0, clk1 = 1'b0, rst_n = 1'b0, sel = 1'b0, en = 1'b1;
  logic out_h, out_l;
  int checks = 0, errors = 0;
  realtime t_rise = -1.0, t_fall = -1.0;

  always #2.5 clk0 = ~clk0;
  initial begin #1.3; forever #3.5 clk1 = ~clk1; end

  clk_switch dut_i (.clk0(clk0), .clk1(clk1), .rst_n(rst_n), .sel(sel), .en(en), .clk_out(out_h));
  clk_switch #(.EN_ACTIVE_HIGH(1'b0)) dut_n (.clk0(clk0), .clk1(clk1), .rst_n(rst_n), .sel(sel), .en(~en), .clk_out(out_l));

  task automatic chk(input bit ok, input string tag, input real act, input real exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual %0.3f expected %0.3f", tag, $realtime, act, exp);
    end
  endtask

  function automatic int exp_src(input bit s, input bit e);
    return e ? int'(s) : -1;
  endfunction

  function automatic bit near(input real a, input real b);
    return (a - b < 0.01) && (b - a < 0.01);
  endfunction

  always @(posedge out_h) begin
    if (rst_n && t_fall >= 0.0)
      chk(($realtime - t_fall) > 2.49, "R6 low gap", $realtime - t_fall, 2.5);
    t_rise = $realtime;
  end

  always @(negedge out_h) begin
    if (rst_n && t_rise >= 0.0)
      chk(near($realtime - t_rise, 2.5) || near($realtime - t_rise, 3.5),
          "R3 high pulse", $realtime - t_rise, 2.5);
    t_fall = $realtime;
  end

  task automatic expect_follow(input int src, input string tag);
    for (int k = 0; k < 4; k++) begin
      if (src == 0)      @(posedge clk0);
      else if (src == 1) @(posedge clk1);
      else               #3.1;
      #0.5;
      chk(out_h == (src >= 0), tag, out_h, src >= 0);
      chk(out_l == out_h, "R4 polarity", out_l, out_h);
      if (src == 0)      @(negedge clk0);
      else if (src == 1) @(negedge clk1);
      else               #2.3;
      #0.5;
      chk(out_h == 1'b0, tag, out_h, 0);
      chk(out_l == out_h, "R4 polarity", out_l, out_h);
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd41));
    #12.2 rst_n = 1'b1;
    expect_follow(0, "R1 reset follows clk0");
    // R5: select flips mid high phase of clk0
    @(posedge clk0); #0.2 sel = 1'b1;
    #0.5 chk(out_h == 1'b1, "R5 old high kept", out_h, 1);
    #120;
    expect_follow(1, "R7 to clk1");
    @(posedge clk1); #0.2 sel = 1'b0;
    #0.5 chk(out_h == 1'b1, "R5 old high kept", out_h, 1);
    #120;
    expect_follow(0, "R7 to clk0");
    @(posedge clk0); #0.3 en = 1'b0;
    #0.5 chk(out_h == 1'b1, "R3 gate waits low", out_h, 1);
    #120;
    expect_follow(-1, "R2 gated low");
    en = 1'b1; #120;
    expect_follow(0, "R2 gate reopened");
    for (int n = 0; n < 40; n++) begin
      #($urandom % 20);
      sel = $urandom % 2;
      en  = ($urandom % 4) != 0;
      #120;
      expect_follow(exp_src(sel, en), en ? "R7 random follow" : "R2 random gate");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule